// File: doc/BRIEF.md
# Spot Centroid Accumulator

This block computes the centre of one labelled spot in a streamed image. It watches a stream of labelled pixels, each carrying its column and row position. A fixed parameter ties the block to one label value. It adds up the column and row coordinates of every pixel that carries that label and counts those pixels. The block runs alongside the pixel stream, so a system that tracks many spots places one copy per label value and feeds all copies the same stream.

When the frame-end strobe arrives, the block hands the totals of the ending frame to a shared restoring divider. The divider works out the mean column and then the mean row. When both quotients are ready, the block publishes them together with the pixel count and raises a one-cycle valid pulse. The published values stay unchanged until the next pulse. The running totals restart at once, so the next frame's pixels are collected while the division is still in progress.

Top module: `spot_centroid`

## Requirements
- R1: After a synchronous active-low reset, `cent_x_o`, `cent_y_o` and `area_o` are zero and `cent_valid_o` is low.
- R2: A pixel is counted only when `pix_valid_i` is 1 and `pix_label_i` equals the parameter `LABEL_ID`. All other cycles leave the running count and the sums unchanged.
- R3: On a result, `cent_x_o` is the floor of the sum of counted column positions divided by the count, and `cent_y_o` is the same for row positions. Both are 9-bit values in the range 0..511.
- R4: The count saturates at 255 (8 bits). Matching pixels that arrive after the 255th pixel of a frame are ignored in the count and in both sums. `area_o` reports the count.
- R5: `cent_x_o`, `cent_y_o` and `area_o` change only in a cycle where `cent_valid_o` is high. At all other times they hold their previous values.
- R6: `cent_valid_o` is a single-cycle pulse, and it is raised at most once per frame end.
- R7: A frame that ends with a count of zero starts no division and raises no pulse. The previous results stay on the outputs.
- R8: A counted pixel that comes in the same cycle as `frame_end_i` belongs to the ending frame. A pixel that comes in the next cycle is the first pixel of the new frame.
- R9: A frame end that arrives while a division is still running still restarts the sums, but that frame publishes no result. The division already running completes normally.
- R10: For a frame with a nonzero count, `cent_valid_o` rises within 2×17+8 clock cycles after the cycle in which `frame_end_i` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pix_valid_i | input | 1 | Pixel qualifier |
| pix_label_i | input | 8 | Label of the current pixel |
| pix_x_i | input | 9 | Column position of the pixel |
| pix_y_i | input | 9 | Row position of the pixel |
| frame_end_i | input | 1 | Marks the last cycle of a frame |
| cent_x_o | output | 9 | Mean column of the spot |
| cent_y_o | output | 9 | Mean row of the spot |
| area_o | output | 8 | Pixel count of the spot |
| cent_valid_o | output | 1 | One-cycle pulse when new results are published |

## Verification
The assertions check four things on every cycle:
- non-matching cycles leave the running count unchanged;
- the count stays at its ceiling once it gets there;
- the count is cleared in the cycle right after a frame end;
- the published values are stable between pulses, and every pulse lasts one cycle and comes with a nonzero area.

Only the bench scenarios can show that the quotients are the correct floor means. The same holds for the truncated sums after saturation, for the frame assignment of a pixel that arrives with the frame-end strobe, and for a result being dropped when frame ends come too close together.

// File: rtl/spot_cen_pkg.sv
// Shared types for the spot centroid block.
// Assumes: nothing beyond IEEE 1800-2017.
package spot_cen_pkg;

    // Sequencer phase: idle, dividing the column sum, dividing the row sum.
    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_COL  = 2'd1,
        SEQ_ROW  = 2'd2
    } seq_state_t;

endpackage

// File: rtl/spot_cen_accum.sv
// Running accumulator for one label value.
// Adds the coordinates of matching pixels and counts them, saturating the count.
// At frame end it snapshots the totals (including a pixel in that cycle),
// pulses frame_done_o, and restarts the running totals from zero.
// Assumes: coordinates are unsigned, and sums are wide enough for CNT_MAX * coordinate max.
module spot_cen_accum #(
    parameter int LABEL_W  = 8,
    parameter int LABEL_ID = 5,
    parameter int COORD_W  = 9,
    parameter int AREA_W   = 8,
    parameter int SUM_W    = COORD_W + AREA_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pix_valid_i,
    input  logic [LABEL_W-1:0] pix_label_i,
    input  logic [COORD_W-1:0] pix_x_i,
    input  logic [COORD_W-1:0] pix_y_i,
    input  logic               frame_end_i,
    output logic [AREA_W-1:0]  run_area_o,
    output logic [SUM_W-1:0]   tot_sx_o,
    output logic [SUM_W-1:0]   tot_sy_o,
    output logic [AREA_W-1:0]  tot_area_o,
    output logic               frame_done_o
);

    localparam logic [LABEL_W-1:0] MY_LABEL = LABEL_W'(LABEL_ID);
    localparam logic [AREA_W-1:0]  CNT_MAX  = '1;

    logic [AREA_W-1:0] run_cnt;
    logic [SUM_W-1:0]  run_sx;
    logic [SUM_W-1:0]  run_sy;
    logic              hit;
    logic [AREA_W-1:0] nxt_cnt;
    logic [SUM_W-1:0]  nxt_sx;
    logic [SUM_W-1:0]  nxt_sy;

    // Qualify the pixel and form the updated totals.
    always_comb begin
        hit     = pix_valid_i && (pix_label_i == MY_LABEL) && (run_cnt != CNT_MAX);
        nxt_cnt = hit ? run_cnt + AREA_W'(1) : run_cnt;
        nxt_sx  = hit ? run_sx + SUM_W'(pix_x_i) : run_sx;
        nxt_sy  = hit ? run_sy + SUM_W'(pix_y_i) : run_sy;
    end

    // Update the running totals, snapshotting and clearing them at frame end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt      <= '0;
            run_sx       <= '0;
            run_sy       <= '0;
            tot_sx_o     <= '0;
            tot_sy_o     <= '0;
            tot_area_o   <= '0;
            frame_done_o <= 1'b0;
        end else if (frame_end_i) begin
            tot_sx_o     <= nxt_sx;
            tot_sy_o     <= nxt_sy;
            tot_area_o   <= nxt_cnt;
            run_cnt      <= '0;
            run_sx       <= '0;
            run_sy       <= '0;
            frame_done_o <= 1'b1;
        end else begin
            run_cnt      <= nxt_cnt;
            run_sx       <= nxt_sx;
            run_sy       <= nxt_sy;
            frame_done_o <= 1'b0;
        end
    end

    assign run_area_o = run_cnt;

endmodule

// File: rtl/spot_cen_divider.sv
// Restoring sequential divider: one quotient bit per cycle, DIVIDEND_W cycles.
// start_i loads the operands; done_o pulses for one cycle once the quotient is final.
// Assumes: divisor nonzero, start_i only raised while idle, and the quotient
// fits in QUOT_W bits (the mean of coordinates never exceeds the coordinate range).
module spot_cen_divider #(
    parameter int DIVIDEND_W = 17,
    parameter int DIVISOR_W  = 8,
    parameter int QUOT_W     = 9
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic [DIVIDEND_W-1:0] dividend_i,
    input  logic [DIVISOR_W-1:0]  divisor_i,
    output logic [QUOT_W-1:0]     quot_o,
    output logic                  done_o
);

    localparam int CNT_W = $clog2(DIVIDEND_W + 1);
    localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(DIVIDEND_W - 1);

    logic [DIVIDEND_W-1:0] quo;
    logic [DIVISOR_W-1:0]  rem;
    logic [DIVISOR_W-1:0]  dvs;
    logic [CNT_W-1:0]      step;
    logic                  busy;
    logic [DIVISOR_W:0]    shifted;
    logic                  fits;

    // Trial subtraction of the divisor from the shifted partial remainder.
    always_comb begin
        shifted = {rem, quo[DIVIDEND_W-1]};
        fits    = shifted >= {1'b0, dvs};
    end

    // Iterate: shift in the next dividend bit and record one quotient bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quo    <= '0;
            rem    <= '0;
            dvs    <= '0;
            step   <= '0;
            busy   <= 1'b0;
            done_o <= 1'b0;
        end else if (start_i) begin
            quo    <= dividend_i;
            rem    <= '0;
            dvs    <= divisor_i;
            step   <= '0;
            busy   <= 1'b1;
            done_o <= 1'b0;
        end else if (busy) begin
            rem    <= fits ? DIVISOR_W'(shifted - {1'b0, dvs}) : shifted[DIVISOR_W-1:0];
            quo    <= {quo[DIVIDEND_W-2:0], fits};
            step   <= step + CNT_W'(1);
            busy   <= (step != LAST_STEP);
            done_o <= (step == LAST_STEP);
        end else begin
            done_o <= 1'b0;
        end
    end

    assign quot_o = quo[QUOT_W-1:0];

endmodule

// File: rtl/spot_centroid.sv
// Per-label spot centroid unit.
// Accumulates matching pixels each frame. At frame end it divides the column sum
// and then the row sum by the pixel count using one shared divider, and publishes
// both means with a one-cycle valid pulse.
// Assumes: frames are longer than one division sequence (about 2*SUM_W+4 cycles).
// A frame end that arrives during a division publishes nothing.
module spot_centroid #(
    parameter int LABEL_W  = 8,
    parameter int LABEL_ID = 5,
    parameter int COORD_W  = 9,
    parameter int AREA_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pix_valid_i,
    input  logic [LABEL_W-1:0] pix_label_i,
    input  logic [COORD_W-1:0] pix_x_i,
    input  logic [COORD_W-1:0] pix_y_i,
    input  logic               frame_end_i,
    output logic [COORD_W-1:0] cent_x_o,
    output logic [COORD_W-1:0] cent_y_o,
    output logic [AREA_W-1:0]  area_o,
    output logic               cent_valid_o
);
    import spot_cen_pkg::*;

    localparam int SUM_W = COORD_W + AREA_W;

    logic [AREA_W-1:0]  acc_area;
    logic [SUM_W-1:0]   tot_sx;
    logic [SUM_W-1:0]   tot_sy;
    logic [AREA_W-1:0]  tot_area;
    logic               frm_done;
    seq_state_t         state;
    logic [SUM_W-1:0]   lat_sy;
    logic [AREA_W-1:0]  lat_area;
    logic [COORD_W-1:0] col_q;
    logic               start_col;
    logic               start_row;
    logic               div_start;
    logic [SUM_W-1:0]   div_num;
    logic [AREA_W-1:0]  div_den;
    logic [COORD_W-1:0] div_q;
    logic               div_done;

    spot_cen_accum #(
        .LABEL_W (LABEL_W),
        .LABEL_ID(LABEL_ID),
        .COORD_W (COORD_W),
        .AREA_W  (AREA_W),
        .SUM_W   (SUM_W)
    ) u_accum (
        .clk         (clk),
        .rst_n       (rst_n),
        .pix_valid_i (pix_valid_i),
        .pix_label_i (pix_label_i),
        .pix_x_i     (pix_x_i),
        .pix_y_i     (pix_y_i),
        .frame_end_i (frame_end_i),
        .run_area_o  (acc_area),
        .tot_sx_o    (tot_sx),
        .tot_sy_o    (tot_sy),
        .tot_area_o  (tot_area),
        .frame_done_o(frm_done)
    );

    // Choose when the divider starts and which operands it takes.
    always_comb begin
        start_col = (state == SEQ_IDLE) && frm_done && (tot_area != '0);
        start_row = (state == SEQ_COL) && div_done;
        div_start = start_col || start_row;
        div_num   = start_col ? tot_sx : lat_sy;
        div_den   = start_col ? tot_area : lat_area;
    end

    spot_cen_divider #(
        .DIVIDEND_W(SUM_W),
        .DIVISOR_W (AREA_W),
        .QUOT_W    (COORD_W)
    ) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (div_start),
        .dividend_i(div_num),
        .divisor_i (div_den),
        .quot_o    (div_q),
        .done_o    (div_done)
    );

    // Step through the column and row divisions and publish both results together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= SEQ_IDLE;
            lat_sy       <= '0;
            lat_area     <= '0;
            col_q        <= '0;
            cent_x_o     <= '0;
            cent_y_o     <= '0;
            area_o       <= '0;
            cent_valid_o <= 1'b0;
        end else begin
            cent_valid_o <= 1'b0;
            case (state)
                SEQ_IDLE: begin
                    if (start_col) begin
                        lat_sy   <= tot_sy;
                        lat_area <= tot_area;
                        state    <= SEQ_COL;
                    end
                end
                SEQ_COL: begin
                    if (div_done) begin
                        col_q <= div_q;
                        state <= SEQ_ROW;
                    end
                end
                SEQ_ROW: begin
                    if (div_done) begin
                        cent_x_o     <= col_q;
                        cent_y_o     <= div_q;
                        area_o       <= lat_area;
                        cent_valid_o <= 1'b1;
                        state        <= SEQ_IDLE;
                    end
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/spot_centroid_chk.sv
// Assertion checker for spot_centroid, attached through bind.
// Assumes: it sees the top-level ports and the running pixel count.
module spot_centroid_chk #(
    parameter int LABEL_W  = 8,
    parameter int LABEL_ID = 5,
    parameter int COORD_W  = 9,
    parameter int AREA_W   = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               pix_valid_i,
    input logic [LABEL_W-1:0] pix_label_i,
    input logic               frame_end_i,
    input logic [AREA_W-1:0]  acc_area,
    input logic [COORD_W-1:0] cent_x_o,
    input logic [COORD_W-1:0] cent_y_o,
    input logic [AREA_W-1:0]  area_o,
    input logic               cent_valid_o
);

    localparam logic [LABEL_W-1:0] MY_LABEL = LABEL_W'(LABEL_ID);
    localparam logic [AREA_W-1:0]  CNT_MAX  = '1;

    // R2: a cycle without a matching pixel leaves the running count alone
    a_r2_no_match_no_count: assert property (@(posedge clk) disable iff (!rst_n)
        ((!pix_valid_i || pix_label_i != MY_LABEL) && !frame_end_i) |=> (acc_area == $past(acc_area)));

    // R4: once saturated, the count stays at its ceiling until frame end
    a_r4_count_saturates: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_area == CNT_MAX && !frame_end_i) |=> (acc_area == CNT_MAX));

    // R8: the running count is empty in the cycle after frame end
    a_r8_clear_after_end: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end_i |=> (acc_area == '0));

    // R5: published values hold between valid pulses
    a_r5_outputs_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cent_valid_o |-> ($stable(cent_x_o) && $stable(cent_y_o) && $stable(area_o)));

    // R6: the valid strobe lasts a single cycle
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cent_valid_o |=> !cent_valid_o);

    // R7: a published result always has a nonzero area
    a_r7_nonzero_area: assert property (@(posedge clk) disable iff (!rst_n)
        cent_valid_o |-> (area_o != '0));

endmodule

bind spot_centroid spot_centroid_chk #(
    .LABEL_W (LABEL_W),
    .LABEL_ID(LABEL_ID),
    .COORD_W (COORD_W),
    .AREA_W  (AREA_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pix_valid_i (pix_valid_i),
    .pix_label_i (pix_label_i),
    .frame_end_i (frame_end_i),
    .acc_area    (acc_area),
    .cent_x_o    (cent_x_o),
    .cent_y_o    (cent_y_o),
    .area_o      (area_o),
    .cent_valid_o(cent_valid_o)
);

// File: tb/spot_centroid_bench.sv
module spot_centroid_bench;

    localparam int ID      = 5;
    localparam int LAT_MAX = 2 * 17 + 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pix_valid_i = 1'b0;
    logic [7:0] pix_label_i = '0;
    logic [8:0] pix_x_i = '0;
    logic [8:0] pix_y_i = '0;
    logic       frame_end_i = 1'b0;
    logic [8:0] cent_x_o;
    logic [8:0] cent_y_o;
    logic [7:0] area_o;
    logic       cent_valid_o;

    int checks = 0;
    int errors = 0;
    int pulses = 0;
    int e_n = 0, e_sx = 0, e_sy = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    spot_centroid u_spot_centroid (
        .clk(clk), .rst_n(rst_n), .pix_valid_i(pix_valid_i), .pix_label_i(pix_label_i),
        .pix_x_i(pix_x_i), .pix_y_i(pix_y_i), .frame_end_i(frame_end_i),
        .cent_x_o(cent_x_o), .cent_y_o(cent_y_o), .area_o(area_o), .cent_valid_o(cent_valid_o)
    );

    // Count valid pulses, sampled shortly after each rising edge.
    always @(posedge clk) begin
        #1;
        if (rst_n && cent_valid_o) pulses++;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive one cycle; track the expected totals of the current frame.
    task automatic drive(input bit v, input int lab, input int x, input int y, input bit fe);
        @(negedge clk);
        pix_valid_i = v;
        pix_label_i = 8'(lab);
        pix_x_i     = 9'(x);
        pix_y_i     = 9'(y);
        frame_end_i = fe;
        if (v && lab == ID && e_n < 255) begin
            e_n++;
            e_sx += x;
            e_sy += y;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(0, 0, 0, 0, 0);
    endtask

    task automatic new_frame();
        e_n = 0; e_sx = 0; e_sy = 0;
    endtask

    // Close the frame, wait for one result and compare it with the floor means.
    task automatic finish_and_check(input string req);
        int p0, wait_n, ex, ey, en;
        en = e_n; ex = e_sx / e_n; ey = e_sy / e_n;
        p0 = pulses;
        drive(0, 0, 0, 0, 1);
        new_frame();
        wait_n = 0;
        while (pulses == p0 && wait_n < LAT_MAX + 2) begin
            drive(0, 0, 0, 0, 0);
            wait_n++;
        end
        chk(pulses == p0 + 1, "R10 result latency", wait_n, LAT_MAX);
        chk(32'(cent_x_o) == ex, {req, " R3 column mean"}, cent_x_o, ex);
        chk(32'(cent_y_o) == ey, {req, " R3 row mean"}, cent_y_o, ey);
        chk(32'(area_o) == en, {req, " area"}, area_o, en);
        idle(4);
        chk(pulses == p0 + 1, "R6 one pulse per frame", pulses - p0, 1);
    endtask

    initial begin
        #1500000;
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int px0, cx0, cy0, a0, n;
        repeat (3) @(negedge clk);
        chk(cent_x_o == 0 && cent_y_o == 0, "R1 reset coords", cent_x_o, 0);
        chk(area_o == 0 && cent_valid_o == 0, "R1 reset area/valid", area_o, 0);
        rst_n = 1'b1;
        idle(2);

        // Extremes of the coordinate range.
        new_frame();
        drive(1, ID, 511, 511, 0);
        finish_and_check("single pixel at max");
        new_frame();
        drive(1, ID, 0, 0, 0);
        drive(1, ID, 1, 0, 0);
        finish_and_check("two pixels floor");

        // Sweep of frames with mixed labels and invalid cycles (R2, R3).
        for (int f = 1; f <= 12; f++) begin
            new_frame();
            n = f * 7;
            for (int k = 0; k < n; k++) begin
                drive(1, ID, (k * 37 + f * 11) % 512, (k * 53 + f * 5) % 512, 0);
                drive(1, ID + 1 + (k % 3), (k * 91) % 512, 7, 0);
                drive(0, ID, 500, 500, 0);
            end
            finish_and_check("R2 sweep");
        end

        // R4: saturation after 255 pixels.
        new_frame();
        for (int k = 0; k < 300; k++) drive(1, ID, (k * 3 + 100) % 512, (k * 5) % 512, 0);
        chk(e_n == 255, "R4 bench model count", e_n, 255);
        finish_and_check("R4 saturation");

        // R7: zero-area frame publishes nothing and holds outputs.
        px0 = pulses; cx0 = cent_x_o; cy0 = cent_y_o; a0 = area_o;
        new_frame();
        drive(1, ID + 2, 10, 10, 0);
        drive(0, ID, 20, 20, 1);
        idle(LAT_MAX + 5);
        chk(pulses == px0, "R7 no pulse on empty frame", pulses - px0, 0);
        chk(32'(cent_x_o) == cx0 && 32'(cent_y_o) == cy0, "R5 coords held", cent_x_o, cx0);
        chk(32'(area_o) == a0, "R5 area held", area_o, a0);

        // R8: pixel with frame end belongs to the ending frame; next cycle starts new one.
        new_frame();
        drive(1, ID, 100, 200, 0);
        drive(1, ID, 400, 100, 1);
        px0 = pulses;
        new_frame();
        drive(1, ID, 10, 20, 0);
        idle(LAT_MAX + 2);
        chk(pulses == px0 + 1, "R8 ending frame published", pulses - px0, 1);
        chk(cent_x_o == 250 && cent_y_o == 150, "R8 frame-end pixel included", cent_x_o, 250);
        chk(area_o == 2, "R8 area of ending frame", area_o, 2);
        drive(1, ID, 30, 40, 0);
        finish_and_check("R8 new frame starts next cycle");

        // R9: frame end during a running division is dropped.
        new_frame();
        drive(1, ID, 60, 80, 0);
        drive(1, ID, 62, 82, 0);
        drive(0, 0, 0, 0, 1);
        px0 = pulses;
        new_frame();
        drive(1, ID, 300, 300, 0);
        drive(0, 0, 0, 0, 1);
        new_frame();
        idle(2 * LAT_MAX);
        chk(pulses == px0 + 1, "R9 only first result", pulses - px0, 1);
        chk(cent_x_o == 61 && cent_y_o == 81, "R9 first frame values", cent_x_o, 61);
        drive(1, ID, 7, 9, 0);
        drive(1, ID, 8, 9, 0);
        finish_and_check("R9 sums cleared by dropped frame");

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule